// File: doc/BRIEF.md
# Lookup Result Priority Resolver

For every packet, three searches return results to this block: a primary filter, an auxiliary filter and a route lookup. Each result is a 32-bit word that holds completion and match flags, a filter priority and the word address of the full forwarding record. The block gathers the three words, decides which forwarding record the packet follows, and reports that decision for a single cycle.

The choice is made only between the primary filter and the route lookup. A primary filter carries its own priority inside its result word. All routes share one priority value, which comes from a configuration register. The auxiliary filter never competes in this choice. When it matches, it asks for one extra copy of the packet, and that copy is forwarded by the auxiliary filter's own record. If neither the primary filter nor the route lookup matches, the block raises a no-route exception so that the packet can be handled elsewhere.

Results arrive in a fixed sequence: primary filter, then auxiliary filter, then route. The block tracks that sequence and accepts only the result that is due next.

Top module: `lkres_resolver`

## Requirements
- R1: Result word layout: bit 31 is Done, bit 30 is Hit, bit 29 is multi-hit, bits 28:21 are the 8-bit priority and bits 20:0 are the 21-bit record word address. A result matches when both Done and Hit are 1.
- R2: A decision is emitted only after all three results have been accepted in the order primary, auxiliary, route. `dec_valid` is high for exactly the one cycle that follows the clock edge that accepted the route result.
- R3: A strobe for a result that is not the one due next is ignored, and so is a strobe whose Done bit is 0. Neither one advances the sequence or produces a decision.
- R4: When both the primary filter and the route match, the higher of the primary priority and `route_prio` wins. `sel_src` is 1 for primary and 2 for route. `sel_addr` and `sel_mhit` come from the winning word.
- R5: When the two priorities are equal, the primary filter wins.
- R6: When only one of the primary filter and the route matches, that one is selected with no priority comparison.
- R7: When neither matches, `no_route` is 1, `sel_src` is 0, and `sel_addr` and `sel_mhit` are 0.
- R8: An auxiliary match sets `aux_copy` to 1, with `aux_addr` taken from the auxiliary word, whatever the primary/route outcome. Without an auxiliary match both are 0. Every decision output is 0 while `dec_valid` is 0.
- R9: The priority fields of the auxiliary and route words have no effect. Only `route_prio` stands for the route.
- R10: After reset, all outputs are 0 and the block waits for a primary result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_prio | input | 8 | Shared route priority from configuration |
| pf_valid | input | 1 | Primary filter result strobe |
| pf_word | input | 32 | Primary filter result word |
| af_valid | input | 1 | Auxiliary filter result strobe |
| af_word | input | 32 | Auxiliary filter result word |
| rt_valid | input | 1 | Route result strobe |
| rt_word | input | 32 | Route result word |
| dec_valid | output | 1 | Decision valid, one cycle |
| sel_src | output | 2 | Winner: 0 none, 1 primary, 2 route |
| sel_addr | output | 21 | Word address of the winning record |
| sel_mhit | output | 1 | Multi-hit flag of the winning word |
| aux_copy | output | 1 | Extra copy requested by the auxiliary filter |
| aux_addr | output | 21 | Word address of the auxiliary record |
| no_route | output | 1 | Neither primary filter nor route matched |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle width of the decision pulse, the quiet outputs between decisions, the agreement between `no_route` and `sel_src`, a zero `aux_addr` whenever no copy is requested, and the legality of the sequencing state. The bench's scenarios cover what a single cycle cannot show. That includes which source wins for each priority relation, ties, single-sided matches, and whether priority bits in the auxiliary and route words leak into the choice. It also includes discarding strobes that arrive out of turn or before completion, and the absence of any decision that was not earned.

// File: rtl/lkres_pkg.sv
package lkres_pkg;
   localparam int CH_PF = 0;
   localparam int CH_AF = 1;
   localparam int CH_RT = 2;
   localparam int N_CH  = 3;

   localparam logic [1:0] SRC_NONE    = 2'd0;
   localparam logic [1:0] SRC_PRIMARY = 2'd1;
   localparam logic [1:0] SRC_ROUTE   = 2'd2;

   localparam logic [1:0] ST_PF = 2'd0;
   localparam logic [1:0] ST_AF = 2'd1;
   localparam logic [1:0] ST_RT = 2'd2;
endpackage

// File: rtl/lkres_field.sv
module lkres_field #(
   parameter int WORD_W = 32,
   parameter int PRIO_W = 8,
   parameter int ADDR_W = 21
) (
   input  logic [WORD_W-1:0] word,
   output logic              done,
   output logic              hit,
   output logic              mhit,
   output logic [PRIO_W-1:0] prio,
   output logic [ADDR_W-1:0] addr
);
   localparam int DONE_B   = WORD_W - 1;
   localparam int HIT_B    = WORD_W - 2;
   localparam int MHIT_B   = WORD_W - 3;
   localparam int PRIO_LSB = ADDR_W;

   generate
      if (WORD_W != 3 + PRIO_W + ADDR_W) begin : g_bad_layout
         $error("lkres_field: word width does not match flag, priority and address widths");
      end
      if (PRIO_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("lkres_field: field widths must be positive");
      end
   endgenerate

   // R1: flags at the top, then priority, then address
   assign done = word[DONE_B];
   assign hit  = word[HIT_B];
   assign mhit = word[MHIT_B];
   assign prio = word[PRIO_LSB +: PRIO_W];
   assign addr = word[ADDR_W-1:0];
endmodule

// File: rtl/lkres_seq.sv
module lkres_seq
   import lkres_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] valid,
   input  logic [N_CH-1:0] done,
   output logic            take_pf,
   output logic            take_af,
   output logic            take_rt,
   output logic [1:0]      stage
);
   // R3: only the result due next, and only once it is complete, is taken
   assign take_pf = (stage == ST_PF) && valid[CH_PF] && done[CH_PF];
   assign take_af = (stage == ST_AF) && valid[CH_AF] && done[CH_AF];
   assign take_rt = (stage == ST_RT) && valid[CH_RT] && done[CH_RT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage <= ST_PF;
      end else if (take_pf) begin
         stage <= ST_AF;
      end else if (take_af) begin
         stage <= ST_RT;
      end else if (take_rt) begin
         stage <= ST_PF;
      end
   end

   // R2
   stage_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage != 2'd3);

   // R2
   rt_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_rt |=> (stage == ST_PF));

   // R3
   rt_needs_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage == ST_RT) |-> ($past(stage) != ST_PF));
endmodule

// File: rtl/lkres_arb.sv
module lkres_arb
   import lkres_pkg::*;
#(
   parameter int PRIO_W         = 8,
   parameter int ADDR_W         = 21,
   parameter bit TIE_TO_PRIMARY = 1'b1
) (
   input  logic              pf_hit,
   input  logic [PRIO_W-1:0] pf_prio,
   input  logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_mhit,
   input  logic              rt_hit,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_mhit,
   input  logic [PRIO_W-1:0] route_prio,
   input  logic              af_hit,
   input  logic [ADDR_W-1:0] af_addr,
   output logic [1:0]        src,
   output logic [ADDR_W-1:0] addr,
   output logic              mhit,
   output logic              aux_copy,
   output logic [ADDR_W-1:0] aux_addr,
   output logic              no_route
);
   logic pf_beats;

   // R5: the tie rule is an elaboration choice
   generate
      if (TIE_TO_PRIMARY) begin : g_tie_pf
         assign pf_beats = (pf_prio >= route_prio);
      end else begin : g_tie_rt
         assign pf_beats = (pf_prio > route_prio);
      end
   endgenerate

   // R4 R6 R7
   always_comb begin
      src      = SRC_NONE;
      addr     = '0;
      mhit     = 1'b0;
      no_route = 1'b0;
      if (pf_hit && (!rt_hit || pf_beats)) begin
         src  = SRC_PRIMARY;
         addr = pf_addr;
         mhit = pf_mhit;
      end else if (rt_hit) begin
         src  = SRC_ROUTE;
         addr = rt_addr;
         mhit = rt_mhit;
      end else begin
         no_route = 1'b1;
      end
   end

   // R8: the auxiliary filter only adds a copy
   assign aux_copy = af_hit;
   assign aux_addr = af_hit ? af_addr : '0;
endmodule

// File: rtl/lkres_resolver.sv
module lkres_resolver
   import lkres_pkg::*;
#(
   parameter int WORD_W         = 32,
   parameter int PRIO_W         = 8,
   parameter int ADDR_W         = 21,
   parameter bit TIE_TO_PRIMARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRIO_W-1:0] route_prio,
   input  logic              pf_valid,
   input  logic [WORD_W-1:0] pf_word,
   input  logic              af_valid,
   input  logic [WORD_W-1:0] af_word,
   input  logic              rt_valid,
   input  logic [WORD_W-1:0] rt_word,
   output logic              dec_valid,
   output logic [1:0]        sel_src,
   output logic [ADDR_W-1:0] sel_addr,
   output logic              sel_mhit,
   output logic              aux_copy,
   output logic [ADDR_W-1:0] aux_addr,
   output logic              no_route
);
   logic [N_CH-1:0][WORD_W-1:0] words;
   logic [N_CH-1:0]             ch_done, ch_hit, ch_mhit, ch_valid;
   logic [N_CH-1:0][PRIO_W-1:0] ch_prio;
   logic [N_CH-1:0][ADDR_W-1:0] ch_addr;

   assign words    = {rt_word, af_word, pf_word};
   assign ch_valid = {rt_valid, af_valid, pf_valid};

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_dec
         lkres_field #(.WORD_W(WORD_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_field (
            .word (words[c]),
            .done (ch_done[c]),
            .hit  (ch_hit[c]),
            .mhit (ch_mhit[c]),
            .prio (ch_prio[c]),
            .addr (ch_addr[c])
         );
      end
   endgenerate

   // R9: priority bits of auxiliary and route words are deliberately dropped
   logic unused_fields;
   assign unused_fields = ^{ch_prio[CH_AF], ch_prio[CH_RT], ch_mhit[CH_AF]};

   logic       take_pf, take_af, take_rt;
   logic [1:0] stage;

   lkres_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (ch_valid),
      .done    (ch_done),
      .take_pf (take_pf),
      .take_af (take_af),
      .take_rt (take_rt),
      .stage   (stage)
   );

   logic              pf_hit_q, pf_mhit_q, af_hit_q;
   logic [PRIO_W-1:0] pf_prio_q;
   logic [ADDR_W-1:0] pf_addr_q, af_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_hit_q  <= 1'b0;
         pf_mhit_q <= 1'b0;
         pf_prio_q <= '0;
         pf_addr_q <= '0;
         af_hit_q  <= 1'b0;
         af_addr_q <= '0;
      end else begin
         if (take_pf) begin
            pf_hit_q  <= ch_hit[CH_PF];
            pf_mhit_q <= ch_mhit[CH_PF];
            pf_prio_q <= ch_prio[CH_PF];
            pf_addr_q <= ch_addr[CH_PF];
         end
         if (take_af) begin
            af_hit_q  <= ch_hit[CH_AF];
            af_addr_q <= ch_addr[CH_AF];
         end
      end
   end

   logic [1:0]        a_src;
   logic [ADDR_W-1:0] a_addr, a_aux_addr;
   logic              a_mhit, a_aux, a_nr;

   lkres_arb #(.PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .TIE_TO_PRIMARY(TIE_TO_PRIMARY)) u_arb (
      .pf_hit     (pf_hit_q),
      .pf_prio    (pf_prio_q),
      .pf_addr    (pf_addr_q),
      .pf_mhit    (pf_mhit_q),
      .rt_hit     (ch_hit[CH_RT]),
      .rt_addr    (ch_addr[CH_RT]),
      .rt_mhit    (ch_mhit[CH_RT]),
      .route_prio (route_prio),
      .af_hit     (af_hit_q),
      .af_addr    (af_addr_q),
      .src        (a_src),
      .addr       (a_addr),
      .mhit       (a_mhit),
      .aux_copy   (a_aux),
      .aux_addr   (a_aux_addr),
      .no_route   (a_nr)
   );

   // R2 R10: the decision is registered and held for a single cycle
   always_ff @(posedge clk) begin
      if (!rst_n || !take_rt) begin
         dec_valid <= 1'b0;
         sel_src   <= SRC_NONE;
         sel_addr  <= '0;
         sel_mhit  <= 1'b0;
         aux_copy  <= 1'b0;
         aux_addr  <= '0;
         no_route  <= 1'b0;
      end else begin
         dec_valid <= 1'b1;
         sel_src   <= a_src;
         sel_addr  <= a_addr;
         sel_mhit  <= a_mhit;
         aux_copy  <= a_aux;
         aux_addr  <= a_aux_addr;
         no_route  <= a_nr;
      end
   end

   // R2
   dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!aux_copy && !no_route && sel_src == SRC_NONE && sel_addr == '0));

   // R7
   noroute_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (no_route == (sel_src == SRC_NONE)));

   // R8
   aux_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_copy |-> (aux_addr == '0));
endmodule

// File: tb/lkres_resolver_tb.sv
`timescale 1ns/100ps
module lkres_resolver_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  route_prio = 8'd5;
   logic        pf_valid = 1'b0, af_valid = 1'b0, rt_valid = 1'b0;
   logic [31:0] pf_word = '0, af_word = '0, rt_word = '0;
   logic        dec_valid, sel_mhit, aux_copy, no_route;
   logic [1:0]  sel_src;
   logic [20:0] sel_addr, aux_addr;

   always #2.5 clk = ~clk;

   lkres_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .route_prio(route_prio),
      .pf_valid(pf_valid), .pf_word(pf_word),
      .af_valid(af_valid), .af_word(af_word),
      .rt_valid(rt_valid), .rt_word(rt_word),
      .dec_valid(dec_valid), .sel_src(sel_src), .sel_addr(sel_addr),
      .sel_mhit(sel_mhit), .aux_copy(aux_copy), .aux_addr(aux_addr),
      .no_route(no_route)
   );

   typedef struct {
      logic [1:0]  src;
      logic [20:0] addr;
      logic        mhit;
      logic        aux;
      logic [20:0] aaddr;
      logic        nr;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // R1: Done 31, Hit 30, multi-hit 29, priority 28:21, address 20:0
   function automatic logic [31:0] mk(input bit d, input bit h, input bit m,
                                      input logic [7:0] p, input logic [20:0] a);
      return {d, h, m, p, a};
   endfunction

   function automatic exp_t model(input logic [31:0] pf, input logic [31:0] af,
                                  input logic [31:0] rt, input logic [7:0] rp,
                                  input string tag);
      exp_t e;
      bit ph, rh, ah;
      ph = pf[31] & pf[30];
      rh = rt[31] & rt[30];
      ah = af[31] & af[30];
      e.tag = tag;
      e.nr = 1'b0;
      if (ph && (!rh || pf[28:21] >= rp)) begin
         e.src = 2'd1; e.addr = pf[20:0]; e.mhit = pf[29];
      end else if (rh) begin
         e.src = 2'd2; e.addr = rt[20:0]; e.mhit = rt[29];
      end else begin
         e.src = 2'd0; e.addr = '0; e.mhit = 1'b0; e.nr = 1'b1;
      end
      e.aux = ah;
      e.aaddr = ah ? af[20:0] : '0;
      return e;
   endfunction

   // ch: 0 primary, 1 auxiliary, 2 route; one-cycle strobe
   task automatic strobe(input int ch, input logic [31:0] w);
      @(negedge clk);
      case (ch)
         0: begin pf_valid = 1'b1; pf_word = w; end
         1: begin af_valid = 1'b1; af_word = w; end
         default: begin rt_valid = 1'b1; rt_word = w; end
      endcase
      @(negedge clk);
      pf_valid = 1'b0; af_valid = 1'b0; rt_valid = 1'b0;
   endtask

   task automatic pkt(input logic [31:0] pf, input logic [31:0] af,
                      input logic [31:0] rt, input string tag);
      strobe(0, pf);
      strobe(1, af);
      exp_q.push_back(model(pf, af, rt, route_prio, tag));
      strobe(2, rt);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the scoreboard as decisions appear
   always @(negedge clk) begin
      if (rst_n && dec_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 R3", "unexpected decision", 32'(dec_valid), 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(sel_src == e.src, e.tag, "sel_src", 32'(sel_src), 32'(e.src));
            chk(sel_addr == e.addr, e.tag, "sel_addr", 32'(sel_addr), 32'(e.addr));
            chk(sel_mhit == e.mhit, e.tag, "sel_mhit", 32'(sel_mhit), 32'(e.mhit));
            chk(aux_copy == e.aux, e.tag, "aux_copy R8", 32'(aux_copy), 32'(e.aux));
            chk(aux_addr == e.aaddr, e.tag, "aux_addr R8", 32'(aux_addr), 32'(e.aaddr));
            chk(no_route == e.nr, e.tag, "no_route", 32'(no_route), 32'(e.nr));
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk({dec_valid, sel_src, sel_addr, sel_mhit, aux_copy, aux_addr, no_route} == '0,
          "R10", "outputs in reset", 32'(dec_valid), 32'd0);
      rst_n = 1'b1;
      idle(2);
      chk(dec_valid == 1'b0, "R10", "dec_valid after reset", 32'(dec_valid), 32'd0);

      // R4: primary priority above route priority
      pkt(mk(1,1,0,8'd9,21'h00A11), mk(1,0,0,8'd0,21'h0), mk(1,1,0,8'd0,21'h1F00F), "R4 pf-high");
      // R4: primary priority below route priority
      pkt(mk(1,1,0,8'd3,21'h00A12), mk(1,0,0,8'd0,21'h0), mk(1,1,1,8'd0,21'h1F010), "R4 rt-high");
      // R5: tie goes to primary
      pkt(mk(1,1,1,8'd5,21'h00A13), mk(1,0,0,8'd0,21'h0), mk(1,1,0,8'd0,21'h1F011), "R5 tie");
      // R6: only primary hits, low priority still wins
      pkt(mk(1,1,0,8'd1,21'h00A14), mk(1,0,0,8'd0,21'h0), mk(1,0,0,8'd0,21'h1F012), "R6 pf-only");
      // R6 R8: only route hits, auxiliary copy requested
      pkt(mk(1,0,0,8'd200,21'h00A15), mk(1,1,0,8'd0,21'h15555), mk(1,1,0,8'd0,21'h1F013), "R6 R8 rt-only");
      // R7 R8: nothing forwards, auxiliary still copies
      pkt(mk(1,0,0,8'd0,21'h00A16), mk(1,1,0,8'd0,21'h0AAAA), mk(1,0,0,8'd0,21'h1F014), "R7 R8 none");
      // R7: nothing at all
      pkt(mk(1,0,0,8'd0,21'h0), mk(1,0,0,8'd0,21'h0), mk(1,0,0,8'd0,21'h0), "R7 empty");
      // R9: nonzero priority bits in route and auxiliary words are ignored
      pkt(mk(1,1,0,8'd9,21'h00B01), mk(1,1,0,8'hFF,21'h00B02), mk(1,1,0,8'hFF,21'h00B03), "R9 prio-ignored");
      pkt(mk(1,1,0,8'd4,21'h00B04), mk(1,0,0,8'hFF,21'h0), mk(1,1,0,8'h00,21'h00B05), "R9 rt-field-zero");

      // R3: stray strobes out of turn and incomplete results
      strobe(1, mk(1,1,0,8'd0,21'h1DEAD));   // aux before primary
      strobe(2, mk(1,1,0,8'd0,21'h1BEEF));   // route before primary
      strobe(0, mk(0,1,0,8'd99,21'h1CAFE));  // primary not done
      idle(2);
      chk(dec_valid == 1'b0, "R3", "no decision after strays", 32'(dec_valid), 32'd0);
      strobe(0, mk(1,1,0,8'd2,21'h00C01));   // accepted primary
      strobe(2, mk(1,1,0,8'd0,21'h1BEEF));   // route out of turn
      strobe(0, mk(1,1,0,8'd99,21'h1CAFE));  // second primary out of turn
      strobe(1, mk(0,1,0,8'd0,21'h1DEAD));   // aux not done
      strobe(1, mk(1,0,0,8'd0,21'h0));       // accepted aux
      exp_q.push_back(model(mk(1,1,0,8'd2,21'h00C01), mk(1,0,0,8'd0,21'h0),
                            mk(1,1,0,8'd0,21'h00C02), route_prio, "R3 R4 stray-order"));
      strobe(2, mk(1,1,0,8'd0,21'h00C02));
      strobe(2, mk(1,1,0,8'd0,21'h1BEEF));   // extra route after decision
      idle(3);

      // R4 R5 at the top of the priority range
      route_prio = 8'hFF;
      pkt(mk(1,1,0,8'hFE,21'h00D01), mk(1,0,0,8'd0,21'h0), mk(1,1,0,8'd0,21'h00D02), "R4 max-route");
      pkt(mk(1,1,1,8'hFF,21'h1FFFF), mk(1,1,0,8'd0,21'h1FFFE), mk(1,1,0,8'd0,21'h00D03), "R5 R1 max-tie");
      route_prio = 8'd0;
      pkt(mk(1,1,0,8'd0,21'h00D04), mk(1,0,0,8'd0,21'h0), mk(1,1,0,8'd0,21'h00D05), "R5 zero-tie");

      // R2: gaps between strobes
      strobe(0, mk(1,1,0,8'd7,21'h00E01));
      idle(3);
      chk(dec_valid == 1'b0, "R2", "no decision after primary only", 32'(dec_valid), 32'd0);
      strobe(1, mk(1,1,0,8'd0,21'h00E02));
      idle(4);
      chk(dec_valid == 1'b0, "R2", "no decision before route", 32'(dec_valid), 32'd0);
      exp_q.push_back(model(mk(1,1,0,8'd7,21'h00E01), mk(1,1,0,8'd0,21'h00E02),
                            mk(1,0,0,8'd0,21'h0), route_prio, "R2 gaps"));
      strobe(2, mk(1,0,0,8'd0,21'h0));
      idle(4);

      chk(exp_q.size() == 0, "R2", "decisions outstanding", 32'(exp_q.size()), 32'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule